// File: doc/BRIEF.md
# Staged per-core watchdog timer

This block watches over one processor core with a countdown that escalates through three stages. Software writes a configuration word that holds a 16-bit length and a 2-bit mode. The length forms the upper part of a 24-bit down-counter whose lower 8 bits reload as all-ones. The counter steps once every 2^DIV_LOG2 clock cycles. Each time the count runs out, the counter reloads and the watchdog moves one stage further. The first expiry raises an interrupt request, the second raises a non-maskable interrupt request, and the third raises a chip-wide soft-reset request. The mode value sets the highest stage that can be reached.

A poke strobe proves that the core is alive. It sends the watchdog back to idle and starts a fresh period. Writing a configuration of all zeros stops the timer and drops every outstanding request. The live count is always visible on an output, so software can poll it, for example until it falls below 0x10000. The interrupt controller and the reset controller are outside this block. The block only drives the three request levels.

Top module: `wdg_staged_top`

## Requirements
- R1: While reset is asserted and after it is released, count_o is 0 and irq_o, nmi_o and rst_req_o are low until the first configuration write.
- R2: A configuration write (cfg_we_i high at a clock edge) loads count_o with {cfg_len_i, 8'hFF} at that edge. It stores cfg_mode_i and returns all three request outputs low.
- R3: With a nonzero mode, count_o decreases by exactly one every 2^DIV_LOG2 cycles. The first decrement comes 2^DIV_LOG2 edges after the edge of a write or poke.
- R4: The count expires on the step that finds it at 0. The counter then reloads {len, 8'hFF} and the stage advances. irq_o therefore rises exactly 2^DIV_LOG2 x (len+1) x 256 edges after the write edge.
- R5: A second expiry without a poke raises nmi_o, and irq_o stays high.
- R6: A third expiry without a poke raises rst_req_o. It stays high through any later expiries until a poke or a configuration write.
- R7: The mode caps escalation. Mode 1 (2'b01) stops at the interrupt stage, mode 2 (2'b10) stops at the NMI stage, and mode 3 (2'b11) reaches soft reset.
- R8: In mode 0 (2'b00) count_o holds its loaded value and no request output rises.
- R9: A poke (poke_i high at an edge) reloads count_o to {len, 8'hFF} and clears irq_o, nmi_o and rst_req_o at that edge.
- R10: When a poke and an expiry fall on the same edge, the poke wins. The stage stays idle and the count reloads.
- R11: Writing len 0 with mode 0 clears an active rst_req_o, sets count_o to 24'h0000FF and stops counting.
- R12: count_o shows the live counter value every cycle, so a poll sees each decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_len_i | input | 16 | Reload length, upper bits of the counter |
| cfg_mode_i | input | 2 | Highest stage allowed; 0 disables |
| poke_i | input | 1 | Keep-alive strobe |
| count_o | output | 24 | Live counter value |
| irq_o | output | 1 | Stage-one interrupt request (level) |
| nmi_o | output | 1 | Stage-two non-maskable interrupt request (level) |
| rst_req_o | output | 1 | Stage-three soft-reset request (sticky level) |

## Verification
The bench builds the block with DIV_LOG2 = 2, so the counter steps every 4 cycles. With length 0 one period is 1024 cycles, and with length 1 it is 2048 cycles. Because periods are this short, all three stages of every mode can be reached many times within the run. The exact cycle of the first expiry can also be hit, both with and without a poke landing on the same edge. The 16/8 split of the counter is kept at its production widths, so the reload pattern seen on count_o is the real one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Stage encoding matches the mode value that caps it.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_RST  = 2'd3
  } wdg_stage_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr_i)     pre_d = '0;
    else if (en_i) pre_d = pre_q + 1'b1;
  end

  assign tick_o = en_i & ~clr_i & (&pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  localparam int CNT_W = LEN_W + LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, reload;

  assign reload   = {len_i, {LOW_W{1'b1}}};
  assign expire_o = tick_i & ~load_i & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i || expire_o) cnt_d = reload;
    else if (tick_i)        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdg_stage_ctl.sv
module wdg_stage_ctl
  import wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       expire_i,
  input  logic [1:0] cap_i,
  output logic       irq_o,
  output logic       nmi_o,
  output logic       rst_o
);
  wdg_stage_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (clr_i)
      stage_d = ST_IDLE;
    else if (expire_i && (logic'(2'(stage_q) < cap_i)))
      stage_d = wdg_stage_e'(2'(stage_q) + 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_IDLE;
    else         stage_q <= stage_d;
  end

  assign irq_o = (stage_q != ST_IDLE);
  assign nmi_o = (stage_q == ST_NMI) || (stage_q == ST_RST);
  assign rst_o = (stage_q == ST_RST);
endmodule

// File: rtl/wdg_staged_top.sv
module wdg_staged_top #(
  parameter int DIV_LOG2 = 8,
  parameter int LEN_W    = 16,
  parameter int LOW_W    = 8,
  localparam int CNT_W   = LEN_W + LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             poke_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  logic [LEN_W-1:0] len_q, len_sel;
  logic [1:0]       mode_q;
  logic             restart, tick, expire, run_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      mode_q <= '0;
    end else if (cfg_we_i) begin
      len_q  <= cfg_len_i;
      mode_q <= cfg_mode_i;
    end
  end

  assign restart = cfg_we_i | poke_i;
  assign run_en  = (mode_q != 2'd0);
  assign len_sel = cfg_we_i ? cfg_len_i : len_q;

  wdg_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .en_i  (run_en),
    .tick_o(tick)
  );

  wdg_countdown #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (restart),
    .len_i   (len_sel),
    .tick_i  (tick),
    .count_o (count_o),
    .expire_o(expire)
  );

  wdg_stage_ctl u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .expire_i(expire),
    .cap_i   (mode_q),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .rst_o   (rst_req_o)
  );
endmodule

// File: rtl/wdg_staged_chk.sv
module wdg_staged_chk #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  localparam int CNT_W = LEN_W + LOW_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic [1:0]       cfg_mode_i,
  input logic             poke_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             rst_req_o,
  input logic [1:0]       mode_q
);
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (count_o == {$past(cfg_len_i), {LOW_W{1'b1}}}) && !irq_o && !nmi_o && !rst_req_o); // R2
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !poke_i && count_o != '0) |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1)); // R3
  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(count_o) == '0)); // R4
  AST_NMI_AFTER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> irq_o); // R5
  AST_RST_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> nmi_o); // R6
  AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !cfg_we_i && !poke_i) |=> rst_req_o); // R6
  AST_CAP_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1) |-> !nmi_o); // R7
  AST_CAP_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd2) |-> !rst_req_o); // R7
  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0 && !cfg_we_i && !poke_i) |=> $stable(count_o) && !irq_o); // R8
  AST_POKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poke_i |=> !irq_o && !nmi_o && !rst_req_o && (count_o[LOW_W-1:0] == {LOW_W{1'b1}})); // R9
  AST_STOP_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd0) |=> !rst_req_o); // R11
endmodule

bind wdg_staged_top wdg_staged_chk #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .cfg_len_i (cfg_len_i),
  .cfg_mode_i(cfg_mode_i),
  .poke_i    (poke_i),
  .count_o   (count_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o),
  .mode_q    (mode_q)
);

// File: tb/wdg_staged_top_tb_top.sv
module wdg_staged_top_tb_top;
  localparam int DIV_LOG2 = 2;
  localparam int DIV      = 1 << DIV_LOG2;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [15:0] cfg_len_i;
  logic [1:0]  cfg_mode_i;
  logic        poke_i;
  logic [23:0] count_o;
  logic        irq_o, nmi_o, rst_req_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  wdg_staged_top #(.DIV_LOG2(DIV_LOG2)) dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_len_i, .cfg_mode_i, .poke_i,
    .count_o, .irq_o, .nmi_o, .rst_req_o
  );

  // {mode[1:0], len[15:0], final irq, nmi, rst}
  localparam logic [20:0] VEC [6] = '{
    {2'd1, 16'd0, 3'b100},
    {2'd2, 16'd0, 3'b110},
    {2'd3, 16'd0, 3'b111},
    {2'd0, 16'd0, 3'b000},
    {2'd3, 16'd1, 3'b111},
    {2'd2, 16'd1, 3'b110}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int period(int len);
    return DIV * (len + 1) * 256;
  endfunction

  task automatic wr(logic [15:0] len, logic [1:0] mode);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_len_i = len; cfg_mode_i = mode;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic poke();
    poke_i = 1'b1;
    @(negedge clk_i);
    poke_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_len_i = '0; cfg_mode_i = '0; poke_i = 1'b0;
    wait_cyc(3);
    check("R1 count in reset", 32'(count_o), 32'd0);
    check("R1 requests in reset", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    rst_ni = 1'b1;
    wait_cyc(20);
    check("R1 idle after reset", {5'd0, count_o, irq_o, nmi_o, rst_req_o}, 32'd0);

    // Table: escalation per mode and length
    foreach (VEC[i]) begin
      automatic logic [1:0]  m = VEC[i][20:19];
      automatic logic [15:0] l = VEC[i][18:3];
      automatic int p = period(int'(l));
      wr(l, m);
      wait_cyc(p + p / 2);
      check("R4 first stage", {31'd0, irq_o}, {31'd0, (m != 2'd0)});
      check("R7 no nmi yet", {31'd0, nmi_o}, 32'd0);
      wait_cyc(p);
      check("R5 second stage", {31'd0, nmi_o}, {31'd0, (m >= 2'd2)});
      wait_cyc(p);
      check("R7 final stages", {29'd0, irq_o, nmi_o, rst_req_o}, {29'd0, VEC[i][2:0]});
    end

    // R2 / R12 / R3: load value and step timing
    wr(16'h0000, 2'd3);
    check("R2 load value", 32'(count_o), 32'h0000FF);
    check("R2 requests cleared", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    wait_cyc(DIV - 1);
    check("R3 no step before divisor", 32'(count_o), 32'h0000FF);
    wait_cyc(1);
    check("R12 live count steps", 32'(count_o), 32'h0000FE);
    wait_cyc(DIV * 10);
    check("R3 ten more steps", 32'(count_o), 32'h0000F4);

    // R4: exact expiry edge
    wr(16'h0000, 2'd3);
    wait_cyc(period(0) - 1);
    check("R4 before expiry", {31'd0, irq_o}, 32'd0);
    check("R4 count zero before expiry", 32'(count_o), 32'd0);
    wait_cyc(1);
    check("R4 irq at expiry", {31'd0, irq_o}, 32'd1);
    check("R4 reload at expiry", 32'(count_o), 32'h0000FF);

    // R9: poke clears and reloads
    wait_cyc(100);
    poke();
    check("R9 poke clears irq", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    check("R9 poke reloads", 32'(count_o), 32'h0000FF);

    // R10: poke on the expiry edge wins
    wr(16'h0000, 2'd3);
    wait_cyc(period(0) - 1);
    poke();
    check("R10 poke beats expiry irq", {31'd0, irq_o}, 32'd0);
    check("R10 poke beats expiry count", 32'(count_o), 32'h0000FF);

    // R6 / R11: sticky reset request, then full stop
    wr(16'h0000, 2'd3);
    wait_cyc(3 * period(0) + 10);
    check("R6 reset request", {31'd0, rst_req_o}, 32'd1);
    wait_cyc(2 * period(0));
    check("R6 reset request sticky", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd7);
    wr(16'h0000, 2'd0);
    check("R11 stop clears", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    check("R11 stop count", 32'(count_o), 32'h0000FF);
    wait_cyc(2 * period(0));
    check("R8 frozen count", 32'(count_o), 32'h0000FF);
    check("R8 no requests", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule